// File: doc/BRIEF.md
# Polling Receiver Wake-Up Sequencer

This block decides when a polled radio receiver is powered. While polling, it moves through a cycle of three phases. First the receiver sleeps with the signal path off. Then it spends a start-up interval with the path on so the analog chain can settle. Last comes a bit-check phase, in which a separate edge-timing checker judges the incoming demodulated stream.

If the checker rejects the stream, the block goes back to sleep. If the checker accepts it, the block enters a receiving phase that lasts until an OFF strobe arrives. A polling/on select held low overrides the cycle and keeps the receiver in the receiving phase.

Every duration is counted in base-clock ticks, and `tick` is a one-cycle enable marking each tick. The sleep length is the product of three terms: a 5-bit sleep word, an extension factor of 1 or 8, and a sleep unit (1024 by default). The all-ones sleep word parks the block in sleep until a different word is presented. The start-up length is set per baud-range code.

Top module: `poll_wake_seq`

## Requirements
- R1: While `rst_n` is low and immediately after its release the block is in sleep: `active`, `path_en`, `rx_pass` and `chk_start` are all 0.
- R2: A sleep phase lasts one load clock plus `max(1, W*X*SLEEP_UNIT)` ticks. Here W is the sampled `sleep_code` and X is 1 when the sampled `sleep_ext` is 0 and `XSLEEP_HI` when it is 1. With `tick` held high, `active` is therefore low for `1 + max(1, W*X*SLEEP_UNIT)` clocks.
- R3: A sampled `sleep_code` of 31 keeps the block in sleep indefinitely. Once the `sleep_code` input differs from 31, the block takes one clock to notice, reloads the word on the next clock, and then sleeps for the new length.
- R4: `sleep_code` and `sleep_ext` are sampled anew on every entry to sleep. Values present at the time of an earlier sleep have no effect.
- R5: Start-up lasts a fixed number of ticks chosen by `baud_sel`: `SU_R0`, `SU_R1`, `SU_R2` or `SU_R3` for codes 0 to 3 (defaults 2048, 1024, 768, 640).
- R6: At the end of start-up, a nonzero `nbits` moves the block to bit-check and raises `chk_start` for exactly one clock. An `nbits` of 0 (meaning zero bits to check) moves it straight to receiving without raising `chk_start`.
- R7: In bit-check, `chk_fail` returns the block to sleep on the next clock and `chk_pass` moves it to receiving. When both are high together, the fail wins.
- R8: Receiving persists for any number of clocks until `off_cmd` is seen; the block then returns to sleep and polling resumes.
- R9: While `poll_en` is low, the block is in receiving from the next clock on, whatever its phase, and `off_cmd` has no effect.
- R10: `active` and `path_en` are 1 in start-up, bit-check and receiving, and 0 in sleep. `rx_pass` is 1 only in receiving.
- R11: The sleep and start-up counts advance only on clocks where `tick` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Base-clock tick enable |
| sleep_code | input | 5 | Sleep word; 31 means sleep until changed |
| sleep_ext | input | 1 | Sleep extension select (0: x1, 1: x`XSLEEP_HI`) |
| baud_sel | input | 2 | Baud-range code selecting the start-up length |
| nbits | input | 2 | Bits-to-check code; 0 means no bit check |
| poll_en | input | 1 | 1: run the polling cycle; 0: force receiving |
| off_cmd | input | 1 | OFF strobe ending receiving |
| chk_pass | input | 1 | Bit-check success pulse |
| chk_fail | input | 1 | Bit-check failure pulse |
| active | output | 1 | Receiver active indicator |
| path_en | output | 1 | Signal-path enable |
| chk_start | output | 1 | One-clock strobe starting the bit check |
| rx_pass | output | 1 | Data pass-through enable (receiving) |

## Verification
The bench builds the block with `SLEEP_UNIT` = 4 and start-up lengths of 8, 6, 5 and 4 ticks, while keeping `XSLEEP_HI` at 8. These values keep every phase down to tens of clocks. Exact sleep and start-up lengths can then be counted clock by clock for several sleep words, for both extension settings and for all four range codes. They also make room for an all-ones sleep held for hundreds of clocks, followed by its release, and for a stretch with `tick` held low, all inside one short run.

// File: rtl/poll_wake_seq.sv
module poll_wake_seq #(
  parameter int SLEEP_UNIT = 1024,
  parameter int XSLEEP_HI  = 8,
  parameter int SU_R0      = 2048,
  parameter int SU_R1      = 1024,
  parameter int SU_R2      = 768,
  parameter int SU_R3      = 640
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic [4:0] sleep_code,
  input  logic       sleep_ext,
  input  logic [1:0] baud_sel,
  input  logic [1:0] nbits,
  input  logic       poll_en,
  input  logic       off_cmd,
  input  logic       chk_pass,
  input  logic       chk_fail,
  output logic       active,
  output logic       path_en,
  output logic       chk_start,
  output logic       rx_pass
);
  localparam int SLP_MAX = 31 * XSLEEP_HI * SLEEP_UNIT;
  localparam int SU_A    = (SU_R0 > SU_R1) ? SU_R0 : SU_R1;
  localparam int SU_B    = (SU_R2 > SU_R3) ? SU_R2 : SU_R3;
  localparam int SU_MAX  = (SU_A > SU_B) ? SU_A : SU_B;
  localparam int TOP     = (SLP_MAX > SU_MAX) ? SLP_MAX : SU_MAX;
  localparam int CW      = $clog2(TOP + 2);

  typedef enum logic [1:0] {S_SLP, S_SU, S_CHK, S_RX} st_t;

  st_t            st;
  logic           ld;
  logic [4:0]     code_q;
  logic           ext_q;
  logic [CW-1:0]  cnt, cnt_nx, slen, sulen;
  logic           hold;

  assign hold   = (code_q == 5'd31);
  assign cnt_nx = cnt + CW'(1);
  assign slen   = CW'(code_q) * CW'(ext_q ? XSLEEP_HI : 1) * CW'(SLEEP_UNIT);

  always_comb begin
    case (baud_sel)
      2'd0:    sulen = CW'(SU_R0);
      2'd1:    sulen = CW'(SU_R1);
      2'd2:    sulen = CW'(SU_R2);
      default: sulen = CW'(SU_R3);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_SLP;
      ld        <= 1'b1;
      code_q    <= '0;
      ext_q     <= 1'b0;
      cnt       <= '0;
      chk_start <= 1'b0;
    end else begin
      chk_start <= 1'b0;
      if (!poll_en) begin
        st  <= S_RX;
        cnt <= '0;
      end else begin
        case (st)
          S_SLP:
            if (ld) begin
              code_q <= sleep_code;
              ext_q  <= sleep_ext;
              cnt    <= '0;
              ld     <= 1'b0;
            end else if (hold) begin
              if (sleep_code != 5'd31) ld <= 1'b1;
            end else if (tick) begin
              if (cnt_nx >= slen) begin
                st  <= S_SU;
                cnt <= '0;
              end else begin
                cnt <= cnt_nx;
              end
            end
          S_SU:
            if (tick) begin
              if (cnt_nx >= sulen) begin
                cnt <= '0;
                if (nbits == 2'd0) begin
                  st <= S_RX;
                end else begin
                  st        <= S_CHK;
                  chk_start <= 1'b1;
                end
              end else begin
                cnt <= cnt_nx;
              end
            end
          S_CHK:
            if (chk_fail) begin
              st <= S_SLP;
              ld <= 1'b1;
            end else if (chk_pass) begin
              st <= S_RX;
            end
          default:
            if (off_cmd) begin
              st <= S_SLP;
              ld <= 1'b1;
            end
        endcase
      end
    end
  end

  assign active  = (st != S_SLP);
  assign path_en = (st != S_SLP);
  assign rx_pass = (st == S_RX);

  p_rx_implies_active_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_pass |-> (active && path_en));

  p_strobe_in_check_r6: assert property (@(posedge clk) disable iff (!rst_n)
    chk_start |-> (active && !rx_pass));

  p_force_rx_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !poll_en |=> rx_pass);

  p_fail_sleeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_CHK && chk_fail && poll_en) |=> !active);

  p_off_sleeps_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_pass && off_cmd && poll_en) |=> !active);

  p_hold_sleep_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SLP && !ld && hold && sleep_code == 5'd31 && poll_en) |=> !active);

  p_no_tick_no_wake_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SLP && !ld && !tick && poll_en) |=> !active);
endmodule

// File: tb/poll_wake_seq_tb_top.sv
`timescale 1ns/1ps
module poll_wake_seq_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b1;
  logic [4:0] sleep_code = 5'd2;
  logic sleep_ext = 1'b0;
  logic [1:0] baud_sel = 2'd0;
  logic [1:0] nbits = 2'd1;
  logic poll_en = 1'b1, off_cmd = 1'b0, chk_pass = 1'b0, chk_fail = 1'b0;
  logic active, path_en, chk_start, rx_pass;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  poll_wake_seq #(.SLEEP_UNIT(4), .XSLEEP_HI(8), .SU_R0(8), .SU_R1(6), .SU_R2(5), .SU_R3(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .sleep_code(sleep_code), .sleep_ext(sleep_ext),
    .baud_sel(baud_sel), .nbits(nbits), .poll_en(poll_en), .off_cmd(off_cmd),
    .chk_pass(chk_pass), .chk_fail(chk_fail), .active(active), .path_en(path_en),
    .chk_start(chk_start), .rx_pass(rx_pass));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic count_low(input int limit, output int n);
    n = 0;
    while (!active && n < limit) begin n++; @(negedge clk); end
  endtask

  task automatic count_su(output int n, output bit strobe);
    n = 0;
    while (!chk_start && !rx_pass && n < 5000) begin n++; @(negedge clk); end
    strobe = chk_start;
  endtask

  task automatic pulse_off();
    off_cmd = 1'b1; @(negedge clk); off_cmd = 1'b0;
  endtask

  task automatic t_reset_first_cycle();
    int n; bit s;
    @(negedge clk);
    chk(!active && !path_en && !rx_pass && !chk_start, "R1 outputs in reset", active, 0);
    rst_n = 1'b1;
    chk(!active && !rx_pass, "R1 sleep after release", active, 0);
    count_low(500, n);
    chk(n == 9, "R2 sleep code2 x1", n, 9);
    chk(active && path_en && !rx_pass, "R10 start-up outputs", active, 1);
    count_su(n, s);
    chk(n == 8, "R5 start-up range0", n, 8);
    chk(s, "R6 strobe at check entry", s, 1);
    @(negedge clk);
    chk(!chk_start && active && !rx_pass, "R6 strobe one clock", chk_start, 0);
  endtask

  task automatic t_fail_resample();
    int n; bit s;
    sleep_code = 5'd1; sleep_ext = 1'b1; baud_sel = 2'd1;
    chk_fail = 1'b1; @(negedge clk); chk_fail = 1'b0;
    chk(!active && !path_en, "R7 fail returns to sleep", active, 0);
    count_low(500, n);
    chk(n == 33, "R4 R2 resampled code1 x8", n, 33);
    count_su(n, s);
    chk(n == 6, "R5 start-up range1", n, 6);
  endtask

  task automatic t_both_pulses();
    int n; bit s;
    sleep_code = 5'd0; sleep_ext = 1'b0; baud_sel = 2'd2;
    chk_fail = 1'b1; chk_pass = 1'b1; @(negedge clk);
    chk_fail = 1'b0; chk_pass = 1'b0;
    chk(!active && !rx_pass, "R7 fail wins over pass", active, 0);
    count_low(500, n);
    chk(n == 2, "R2 code0 one tick", n, 2);
    count_su(n, s);
    chk(n == 5, "R5 start-up range2", n, 5);
  endtask

  task automatic t_pass_hold_release();
    int n; bit s; bit stayed = 1'b1;
    chk_pass = 1'b1; @(negedge clk); chk_pass = 1'b0;
    chk(rx_pass && active, "R7 pass enters receiving", rx_pass, 1);
    for (int i = 0; i < 20; i++) begin @(negedge clk); if (!rx_pass) stayed = 1'b0; end
    chk(stayed, "R8 receiving persists", stayed, 1);
    sleep_code = 5'd31;
    pulse_off();
    chk(!active && !rx_pass, "R8 off returns to sleep", active, 0);
    count_low(200, n);
    chk(n == 200, "R3 code31 holds", n, 200);
    sleep_code = 5'd1; baud_sel = 2'd3; nbits = 2'd0;
    count_low(500, n);
    chk(n == 6, "R3 release after code change", n, 6);
    count_su(n, s);
    chk(n == 4, "R5 start-up range3", n, 4);
    chk(rx_pass && !s, "R6 zero bits goes direct", rx_pass, 1);
  endtask

  task automatic t_tick_gate();
    int n; bit stayed = 1'b1;
    tick = 1'b0;
    pulse_off();
    for (int i = 0; i < 30; i++) begin if (active) stayed = 1'b0; @(negedge clk); end
    chk(stayed, "R11 no tick no progress", stayed, 1);
    tick = 1'b1;
    count_low(500, n);
    chk(n == 4, "R11 counts resume with tick", n, 4);
    @(negedge clk);
    while (!rx_pass && n < 1000) begin n++; @(negedge clk); end
    chk(rx_pass, "R6 reaches receiving", rx_pass, 1);
  endtask

  task automatic t_force();
    sleep_code = 5'd31;
    pulse_off();
    repeat (10) @(negedge clk);
    chk(!active, "R3 parked before force", active, 0);
    poll_en = 1'b0; @(negedge clk);
    chk(rx_pass && active && path_en, "R9 force to receiving", rx_pass, 1);
    pulse_off();
    @(negedge clk);
    chk(rx_pass, "R9 off ignored while forced", rx_pass, 1);
    poll_en = 1'b1; @(negedge clk);
    chk(rx_pass, "R8 stays receiving after release", rx_pass, 1);
    pulse_off();
    chk(!active, "R8 off after force release", active, 0);
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset_first_cycle();
    t_fail_resample();
    t_both_pulses();
    t_pass_hold_release();
    t_tick_gate();
    t_force();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule